// File: doc/BRIEF.md
# Write-Through Cache with Width Adaptation

This block sits in an existing path between a requester and a memory controller. Both sides use the same request shape: a valid/ready request channel that carries write, address, write data and byte mask, and a one-cycle response strobe with read data. The requester word is narrower than the memory word. One memory word is exactly one cache line. The block holds a set-associative tag and data store and picks a victim way by least-recently-used order within the set. It also runs a small controller that fetches a full line on a read miss and passes every write through to memory without allocating a line.

Requests enter a small in-order queue. A request is accepted on an edge where `req_valid` and `req_ready` are both high. The requester may hold `req_valid` for as long as it likes, and the block may hold `req_ready` low for as long as it likes. The memory channel follows the same rule from the other direction: once `mem_valid` is raised, it stays high with every field unchanged until `mem_ready` is seen. Responses carry no back-pressure. `rsp_valid` and `mem_rsp_valid` are one-cycle strobes, and the receiving side must take them.

The queue depth is set by a parameter. A depth of 1 uses a single holding register whose ready comes straight from a flop, and this halves the peak rate. A depth of 2 or more gives one request per cycle.

Top module: `wt_cache`

## Requirements
- R1: A requester address is split into a memory word address (upper MEM_AW bits) and a sub-word index (low log2(MEM_DW/CPU_DW) bits). Sub-word k occupies bits k*CPU_DW to k*CPU_DW+CPU_DW-1 of the memory word, so index 0 is the least significant lane.
- R2: A read that misses issues exactly one memory read, with `mem_write`=0 and `mem_addr` equal to the word address. When `mem_rsp_valid` arrives, the line is stored with its tag and valid bit, and the selected sub-word is returned on `rsp_data` with `rsp_valid` in the following cycle.
- R3: A read that hits returns the cached sub-word without any memory request.
- R4: Every write is forwarded to memory with `mem_write`=1 and the word address. The requester data sits at its sub-word lane of `mem_wdata`, and the requester mask sits at the matching CPU_DW/8 bits of `mem_wmask`. All other mask bits are 0.
- R5: A write that hits also updates the cached line, in only the bytes whose mask bit is 1. A later read hit returns the merged word.
- R6: A write that misses leaves the cache unchanged, so a later read of that address misses.
- R7: On a read miss, the victim is an invalid way if one exists, otherwise the least recently used way of the set. Read hits and line fills both count as uses.
- R8: Requests complete strictly in acceptance order. Each read produces exactly one single-cycle `rsp_valid`, and writes produce none.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr`, `mem_wdata` and `mem_wmask` hold their values into the next cycle.
- R10: With QDEPTH of 2 or more, read hits are accepted on consecutive cycles with `req_ready` staying high. With QDEPTH=1, `req_ready` is low in the cycle after every accepted request.
- R11: Reset is synchronous. While it is applied, `req_ready` is 1, `mem_valid` is 0 and `rsp_valid` is 0. After it is released, every line is invalid, so any read misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Requester offers a request |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | SUB_W+MEM_AW | Requester word address |
| req_wdata | input | CPU_DW | Write data |
| req_wmask | input | CPU_DW/8 | Byte enables for the write |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_data | output | CPU_DW | Read data |
| mem_valid | output | 1 | Memory request offered |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 = write, 0 = line read |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | MEM_DW | Write data placed at its lane |
| mem_wmask | output | MEM_DW/8 | Byte enables for the memory word |
| mem_rsp_valid | input | 1 | One-cycle memory read-data strobe |
| mem_rsp_data | input | MEM_DW | Memory read data, one full line |

## Verification
On every cycle, the assertions check four things: the memory request stays stable under back-pressure, no tag is held in two ways of a set, a line fill never overwrites a hit, and a response strobe always follows the retirement of a read. In the single-register queue mode they also check that ready drops after each accept. Whether the returned data is correct, whether the byte merge on a write hit is right, whether a write miss is left unallocated, and which way LRU evicts can only be shown by the bench scenarios. These scenarios run against a memory model that stalls and delays, and they track hits and misses through counts of memory reads.

// File: rtl/wt_cache_pkg.sv
`timescale 1ns/1ps
package wt_cache_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/wt_cache_reqq.sv
`timescale 1ns/1ps
module wt_cache_reqq #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         pop
);
  generate
    if (DEPTH == 1) begin : g_reg
      logic         full;
      logic [W-1:0] held;

      always_ff @(posedge clk) begin
        if (rst) full <= 1'b0;
        else if (in_valid && in_ready) full <= 1'b1;
        else if (pop) full <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) held <= in_data;
      end

      assign in_ready  = !full;
      assign out_valid = full;
      assign out_data  = held;

      // R10: single-register mode runs at half rate
      assert_half_rate_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
    end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);
      logic [W-1:0]  slots [DEPTH];
      logic [PW-1:0] wp, rp;
      logic [CW-1:0] cnt;
      logic          push, take;

      assign in_ready  = (cnt != CW'(DEPTH));
      assign out_valid = (cnt != '0);
      assign out_data  = slots[rp];
      assign push      = in_valid && in_ready;
      assign take      = pop && out_valid;

      always_ff @(posedge clk) begin
        if (rst) begin
          wp  <= '0;
          rp  <= '0;
          cnt <= '0;
        end else begin
          if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
          if (take) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
          case ({push, take})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
          endcase
        end
      end

      always_ff @(posedge clk) begin
        if (push) slots[wp] <= in_data;
      end
    end
  endgenerate
endmodule

// File: rtl/wt_cache_store.sv
`timescale 1ns/1ps
module wt_cache_store #(
  parameter int LINE_W = 128,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 6,
  localparam int SET_W = $clog2(SETS),
  localparam int BYTES = LINE_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  set_idx,
  input  logic [TAG_W-1:0]  tag,
  output logic              hit,
  output logic [LINE_W-1:0] hit_line,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [BYTES-1:0]  wr_bmask,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              touch_en
);
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]   vld  [SETS];
  logic [TAG_W-1:0]  tags [SETS][WAYS];
  logic [LINE_W-1:0] lines[SETS][WAYS];
  logic [AGE_W-1:0]  ages [SETS][WAYS];

  logic [WAYS-1:0]  hit_vec;
  logic [AGE_W-1:0] hit_way, vic_way, use_way;
  logic             vic_found, do_use;

  // Tag compare across all ways of the addressed set
  always_comb begin
    hit_vec  = '0;
    hit_way  = '0;
    hit_line = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[set_idx][w] && tags[set_idx][w] == tag) begin
        hit_vec[w] = 1'b1;
        hit_way    = AGE_W'(w);
        hit_line   = lines[set_idx][w];
      end
    end
  end
  assign hit = |hit_vec;

  // Victim: lowest invalid way, else the oldest way
  always_comb begin
    vic_way   = '0;
    vic_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vic_found && !vld[set_idx][w]) begin
        vic_way   = AGE_W'(w);
        vic_found = 1'b1;
      end
    end
    if (!vic_found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ages[set_idx][w] == AGE_W'(WAYS - 1)) vic_way = AGE_W'(w);
      end
    end
  end

  assign do_use  = fill_en || touch_en;
  assign use_way = fill_en ? vic_way : hit_way;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        for (int w = 0; w < WAYS; w++) ages[s][w] <= AGE_W'(w);
      end
    end else begin
      if (fill_en) vld[set_idx][vic_way] <= 1'b1;
      if (do_use) begin
        for (int w = 0; w < WAYS; w++) begin
          if (AGE_W'(w) == use_way) ages[set_idx][w] <= '0;
          else if (ages[set_idx][w] < ages[set_idx][use_way])
            ages[set_idx][w] <= ages[set_idx][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      lines[set_idx][vic_way] <= fill_line;
      tags[set_idx][vic_way]  <= tag;
    end else if (wr_en && hit) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_bmask[b]) lines[set_idx][hit_way][b*8 +: 8] <= wr_line[b*8 +: 8];
      end
    end
  end

  // R7: a tag lives in at most one way of its set
  assert_single_way_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  // R2: lines are only filled for addresses that missed
  assert_fill_only_on_miss_R2: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> !hit);
endmodule

// File: rtl/wt_cache_ctrl.sv
`timescale 1ns/1ps
module wt_cache_ctrl
  import wt_cache_pkg::*;
#(
  parameter int CPU_DW = 32,
  parameter int MEM_DW = 128,
  parameter int MEM_AW = 8,
  parameter int SUB_W  = 2,
  localparam int CPU_AW = SUB_W + MEM_AW,
  localparam int CPU_B  = CPU_DW / 8,
  localparam int MEM_B  = MEM_DW / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic              head_write,
  input  logic [CPU_AW-1:0] head_addr,
  input  logic [CPU_DW-1:0] head_wdata,
  input  logic [CPU_B-1:0]  head_wmask,
  output logic              pop,
  input  logic              hit,
  input  logic [MEM_DW-1:0] hit_line,
  output logic              fill_en,
  output logic              wr_en,
  output logic [MEM_B-1:0]  wr_bmask,
  output logic [MEM_DW-1:0] wr_line,
  output logic              touch_en,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0] mem_wdata,
  output logic [MEM_B-1:0]  mem_wmask,
  input  logic              mem_rsp_valid,
  input  logic [MEM_DW-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [CPU_DW-1:0] rsp_data
);
  ctrl_state_e st;
  logic [SUB_W-1:0]  sub;
  logic [MEM_DW-1:0] placed_data;
  logic [MEM_B-1:0]  placed_mask;
  logic [MEM_DW-1:0] src_line;

  assign sub         = head_addr[SUB_W-1:0];
  assign placed_data = MEM_DW'(head_wdata) << (int'(sub) * CPU_DW);
  assign placed_mask = MEM_B'(head_wmask) << (int'(sub) * CPU_B);

  assign mem_write = head_write;
  assign mem_addr  = head_addr[CPU_AW-1:SUB_W];
  assign mem_wdata = placed_data;
  assign mem_wmask = head_write ? placed_mask : '0;
  assign wr_bmask  = placed_mask;
  assign wr_line   = placed_data;

  always_comb begin
    mem_valid = 1'b0;
    pop       = 1'b0;
    wr_en     = 1'b0;
    touch_en  = 1'b0;
    fill_en   = 1'b0;
    if (st == ST_IDLE && head_valid) begin
      if (head_write) begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          pop   = 1'b1;
          wr_en = 1'b1;
        end
      end else if (hit) begin
        pop      = 1'b1;
        touch_en = 1'b1;
      end else begin
        mem_valid = 1'b1;
      end
    end
    if (st == ST_FILL && mem_rsp_valid) begin
      fill_en = 1'b1;
      pop     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else if (st == ST_IDLE && mem_valid && mem_ready && !head_write) st <= ST_FILL;
    else if (st == ST_FILL && mem_rsp_valid) st <= ST_IDLE;
  end

  assign src_line = fill_en ? mem_rsp_data : hit_line;

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= pop && !head_write;
  end

  always_ff @(posedge clk) begin
    if (pop && !head_write) rsp_data <= CPU_DW'(src_line >> (int'(sub) * CPU_DW));
  end

  // R9: a stalled memory request keeps all its fields
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write) && $stable(mem_addr)
                                   && $stable(mem_wdata) && $stable(mem_wmask)));
  // R8: every response strobe follows the retirement of a read at the queue head
  assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(head_valid && !head_write));
endmodule

// File: rtl/wt_cache.sv
`timescale 1ns/1ps
module wt_cache #(
  parameter int CPU_DW = 32,
  parameter int MEM_DW = 128,
  parameter int MEM_AW = 8,
  parameter int LINES  = 8,
  parameter int WAYS   = 2,
  parameter int QDEPTH = 2,
  localparam int SUBS   = MEM_DW / CPU_DW,
  localparam int SUB_W  = $clog2(SUBS),
  localparam int CPU_AW = SUB_W + MEM_AW,
  localparam int CPU_B  = CPU_DW / 8,
  localparam int MEM_B  = MEM_DW / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CPU_AW-1:0] req_addr,
  input  logic [CPU_DW-1:0] req_wdata,
  input  logic [CPU_B-1:0]  req_wmask,
  output logic              rsp_valid,
  output logic [CPU_DW-1:0] rsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0] mem_wdata,
  output logic [MEM_B-1:0]  mem_wmask,
  input  logic              mem_rsp_valid,
  input  logic [MEM_DW-1:0] mem_rsp_data
);
  localparam int SETS  = LINES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = MEM_AW - SET_W;
  localparam int ENT_W = 1 + CPU_AW + CPU_DW + CPU_B;

  logic [ENT_W-1:0]  in_ent, head_ent;
  logic              head_valid, head_write, pop;
  logic [CPU_AW-1:0] head_addr;
  logic [CPU_DW-1:0] head_wdata;
  logic [CPU_B-1:0]  head_wmask;
  logic              hit, fill_en, wr_en, touch_en;
  logic [MEM_DW-1:0] hit_line, wr_line;
  logic [MEM_B-1:0]  wr_bmask;
  logic [MEM_AW-1:0] word_addr;

  assign in_ent = {req_write, req_addr, req_wdata, req_wmask};
  assign {head_write, head_addr, head_wdata, head_wmask} = head_ent;
  assign word_addr = head_addr[CPU_AW-1:SUB_W];

  wt_cache_reqq #(.W(ENT_W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(in_ent),
    .out_valid(head_valid), .out_data(head_ent), .pop(pop)
  );

  wt_cache_store #(.LINE_W(MEM_DW), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .set_idx(word_addr[SET_W-1:0]), .tag(word_addr[MEM_AW-1:SET_W]),
    .hit(hit), .hit_line(hit_line),
    .fill_en(fill_en), .fill_line(mem_rsp_data),
    .wr_en(wr_en), .wr_bmask(wr_bmask), .wr_line(wr_line),
    .touch_en(touch_en)
  );

  wt_cache_ctrl #(.CPU_DW(CPU_DW), .MEM_DW(MEM_DW), .MEM_AW(MEM_AW), .SUB_W(SUB_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .head_valid(head_valid), .head_write(head_write), .head_addr(head_addr),
    .head_wdata(head_wdata), .head_wmask(head_wmask), .pop(pop),
    .hit(hit), .hit_line(hit_line),
    .fill_en(fill_en), .wr_en(wr_en), .wr_bmask(wr_bmask), .wr_line(wr_line),
    .touch_en(touch_en),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: tb/wt_cache_tb.sv
`timescale 1ns/1ps
module wt_cache_memmodel #(
  parameter int AW = 8,
  parameter int DW = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  output logic            ready,
  input  logic            write,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] wmask,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data
);
  logic [DW-1:0] words [2**AW];
  logic [1:0]    tick, lat;
  logic          pend;
  logic [AW-1:0] raddr;

  function automatic logic [DW-1:0] seed(input int w);
    logic [DW-1:0] v = '0;
    for (int s = 0; s < DW / 32; s++) v[s*32 +: 32] = 32'hC000_0000 | (w << 8) | s;
    return v;
  endfunction

  assign ready = (tick == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick      <= '0;
      pend      <= 1'b0;
      lat       <= '0;
      raddr     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      for (int w = 0; w < 2**AW; w++) words[w] <= seed(w);
    end else begin
      tick      <= (tick == 2'd2) ? 2'd0 : tick + 2'd1;
      rsp_valid <= 1'b0;
      if (valid && ready) begin
        if (write) begin
          for (int b = 0; b < DW / 8; b++)
            if (wmask[b]) words[addr][b*8 +: 8] <= wdata[b*8 +: 8];
        end else begin
          pend  <= 1'b1;
          lat   <= 2'd2;
          raddr <= addr;
        end
      end
      if (pend) begin
        if (lat == 2'd0) begin
          pend      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_data  <= words[raddr];
        end else begin
          lat <= lat - 2'd1;
        end
      end
    end
  end
endmodule

module wt_cache_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // DUT with a two-entry queue
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]   req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic [3:0]   req_wmask = '0;
  logic         req_ready, rsp_valid;
  logic [31:0]  rsp_data;
  logic         mem_valid, mem_ready, mem_write, mem_rsp_valid;
  logic [7:0]   mem_addr;
  logic [127:0] mem_wdata, mem_rsp_data;
  logic [15:0]  mem_wmask;

  wt_cache u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  wt_cache_memmodel u_mem (
    .clk(clk), .rst(rst), .valid(mem_valid), .ready(mem_ready), .write(mem_write),
    .addr(mem_addr), .wdata(mem_wdata), .wmask(mem_wmask),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data)
  );

  // Second DUT with the single-register queue
  logic         q1_valid = 1'b0;
  logic         q1_ready, q1_rsp_valid;
  logic [31:0]  q1_rsp_data;
  logic         m1_valid, m1_ready, m1_write, m1_rsp_valid;
  logic [7:0]   m1_addr;
  logic [127:0] m1_wdata, m1_rsp_data;
  logic [15:0]  m1_wmask;

  wt_cache #(.QDEPTH(1)) u_dut1 (
    .clk(clk), .rst(rst),
    .req_valid(q1_valid), .req_ready(q1_ready), .req_write(1'b0),
    .req_addr(10'h016), .req_wdata(32'h0), .req_wmask(4'h0),
    .rsp_valid(q1_rsp_valid), .rsp_data(q1_rsp_data),
    .mem_valid(m1_valid), .mem_ready(m1_ready), .mem_write(m1_write),
    .mem_addr(m1_addr), .mem_wdata(m1_wdata), .mem_wmask(m1_wmask),
    .mem_rsp_valid(m1_rsp_valid), .mem_rsp_data(m1_rsp_data)
  );

  wt_cache_memmodel u_mem1 (
    .clk(clk), .rst(rst), .valid(m1_valid), .ready(m1_ready), .write(m1_write),
    .addr(m1_addr), .wdata(m1_wdata), .wmask(m1_wmask),
    .rsp_valid(m1_rsp_valid), .rsp_data(m1_rsp_data)
  );

  // Monitors, sampled at the falling edge
  int           rd_cnt = 0, wr_cnt = 0, rsp_n = 0;
  logic [7:0]   rd_addr_l = '0, wr_addr_l = '0;
  logic [127:0] wr_data_l = '0;
  logic [15:0]  wr_mask_l = '0;
  logic [31:0]  rsp_log [64];

  always @(negedge clk) begin
    if (!rst && mem_valid && mem_ready) begin
      if (mem_write) begin
        wr_cnt    <= wr_cnt + 1;
        wr_addr_l <= mem_addr;
        wr_data_l <= mem_wdata;
        wr_mask_l <= mem_wmask;
      end else begin
        rd_cnt    <= rd_cnt + 1;
        rd_addr_l <= mem_addr;
      end
    end
    if (!rst && rsp_valid) begin
      rsp_log[rsp_n % 64] <= rsp_data;
      rsp_n <= rsp_n + 1;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic [9:0] a, input logic [31:0] d,
                       input logic [3:0] m, output logic [31:0] got, output int reads);
    int r0, n0, w0, guard;
    @(negedge clk);
    r0 = rd_cnt; n0 = rsp_n; w0 = wr_cnt;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_wmask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    if (!wr) while (rsp_n == n0 && guard < 200) begin @(negedge clk); guard++; end
    else     while (wr_cnt == w0 && guard < 200) begin @(negedge clk); guard++; end
    @(negedge clk);
    got   = rsp_log[(rsp_n - 1) % 64];
    reads = rd_cnt - r0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic [3:0]  wmask;
    logic [31:0] exp;
    logic [1:0]  exp_reads;
    logic [3:0]  tag;
  } vec_t;

  // Memory word w, lane s initially holds C000_0000 | w<<8 | s.
  // Requester address = word*4 + lane; set = word[1:0].
  localparam vec_t [0:13] VECS = '{
    '{1'b0, 10'h016, 32'h0,        4'h0, 32'hC0000502, 2'd1, 4'd2},  // R2 miss, R1 lane 2
    '{1'b0, 10'h014, 32'h0,        4'h0, 32'hC0000500, 2'd0, 4'd3},  // R3 hit lane 0
    '{1'b0, 10'h017, 32'h0,        4'h0, 32'hC0000503, 2'd0, 4'd1},  // R1 top lane
    '{1'b1, 10'h015, 32'hDEADBEEF, 4'h3, 32'h0,        2'd0, 4'd4},  // R4 write hit
    '{1'b0, 10'h015, 32'h0,        4'h0, 32'hC000BEEF, 2'd0, 4'd5},  // R5 merged bytes
    '{1'b1, 10'h01C, 32'h12345678, 4'hF, 32'h0,        2'd0, 4'd6},  // R6 write miss
    '{1'b0, 10'h01C, 32'h0,        4'h0, 32'h12345678, 2'd1, 4'd6},  // R6 still misses
    '{1'b0, 10'h00C, 32'h0,        4'h0, 32'hC0000300, 2'd1, 4'd7},  // R7 second way
    '{1'b0, 10'h01C, 32'h0,        4'h0, 32'h12345678, 2'd0, 4'd7},  // R7 touch word 7
    '{1'b0, 10'h02F, 32'h0,        4'h0, 32'hC0000B03, 2'd1, 4'd7},  // R7 evicts word 3
    '{1'b0, 10'h01C, 32'h0,        4'h0, 32'h12345678, 2'd0, 4'd7},  // R7 word 7 kept
    '{1'b0, 10'h00C, 32'h0,        4'h0, 32'hC0000300, 2'd1, 4'd7},  // R7 evicts word 11
    '{1'b0, 10'h01C, 32'h0,        4'h0, 32'h12345678, 2'd0, 4'd7},  // R7 word 7 kept
    '{1'b0, 10'h02F, 32'h0,        4'h0, 32'hC0000B03, 2'd1, 4'd7}   // R7 word 11 gone
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] got;
    int reads, n0, r0, stalls, viol, acc;
    logic prev_acc;
    logic [31:0] exp4 [4];

    repeat (3) @(negedge clk);
    // R11: outputs while reset is held
    check("R11 ready in reset", 128'(req_ready), 128'(1));
    check("R11 mem_valid in reset", 128'(mem_valid), 128'(0));
    check("R11 rsp_valid in reset", 128'(rsp_valid), 128'(0));
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < 14; i++) begin
      do_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].wmask, got, reads);
      if (!VECS[i].wr)
        check($sformatf("R%0d data step %0d", VECS[i].tag, i), 128'(got), 128'(VECS[i].exp));
      check($sformatf("R%0d reads step %0d", VECS[i].tag, i), 128'(reads), 128'(VECS[i].exp_reads));
    end

    // R2: miss address on the memory port
    do_op(1'b0, 10'h03A, 32'h0, 4'h0, got, reads);
    check("R2 miss data", 128'(got), 128'(32'hC0000E02));
    check("R2 miss addr", 128'(rd_addr_l), 128'(8'd14));
    check("R2 one read", 128'(reads), 128'(1));

    // R4: forwarded write placement in lane 3, byte 3 only
    do_op(1'b1, 10'h01B, 32'hAABBCCDD, 4'h8, got, reads);
    check("R4 write addr", 128'(wr_addr_l), 128'(8'd6));
    check("R4 write mask", 128'(wr_mask_l), 128'(16'h8000));
    check("R4 write lane", 128'(wr_data_l[127:96]), 128'(32'hAABBCCDD));

    // R8 and R10: four back-to-back hits, in order, no stall
    exp4[0] = 32'hC0000500; exp4[1] = 32'hC000BEEF;
    exp4[2] = 32'hC0000502; exp4[3] = 32'hC0000503;
    @(negedge clk);
    n0 = rsp_n; r0 = rd_cnt; stalls = 0;
    req_write = 1'b0; req_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      req_addr = 10'h014 + 10'(i);
      if (!req_ready) stalls++;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 no stall on hits", 128'(stalls), 128'(0));
    check("R8 response count", 128'(rsp_n - n0), 128'(4));
    check("R3 no memory reads", 128'(rd_cnt - r0), 128'(0));
    for (int i = 0; i < 4; i++)
      check($sformatf("R8 order %0d", i), 128'(rsp_log[(n0 + i) % 64]), 128'(exp4[i]));

    // R10: single-register queue drops ready after each accept
    viol = 0; acc = 0; prev_acc = 1'b0;
    q1_valid = 1'b1;
    for (int c = 0; c < 40; c++) begin
      if (prev_acc && q1_ready) viol++;
      prev_acc = q1_valid && q1_ready;
      if (prev_acc) acc++;
      @(negedge clk);
    end
    q1_valid = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 half rate", 128'(viol), 128'(0));
    check("R10 progress", 128'(acc >= 3), 128'(1));

    // R11: reset mid-run invalidates all lines
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 ready in reset", 128'(req_ready), 128'(1));
    check("R11 mem_valid in reset", 128'(mem_valid), 128'(0));
    rst = 1'b0;
    do_op(1'b0, 10'h014, 32'h0, 4'h0, got, reads);
    check("R11 miss after reset", 128'(reads), 128'(1));
    check("R11 data after reset", 128'(got), 128'(32'hC0000500));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule